// File: doc/BRIEF.md
# Symbol-Error Lock Detector

This block decides whether the loops of a QAM demodulator have converged. Each decided equalizer output symbol arrives with a flag that says whether it landed inside one of the error-indicating regions of the constellation; that flag is computed upstream. The block counts these flags over an observation window of a selectable number of symbols. At the end of each window it compares the count with a programmable threshold and updates a lock flag.

The count taken over the last complete window is held on an 8-bit output. It can be read as a coarse symbol-error-rate estimate. The lock flag also drives the carrier-recovery detector select. While the loops are not locked, the phase-frequency detector pulls the carrier in. Once lock is declared, the faster phase-only detector takes over.

Top module: `area_lock_detector`

## Requirements
- R1: While reset is held and after it is released, the lock flag is 0, the detector select is 0 (phase-frequency detector), and the held count is 255. These values remain until the first window completes.
- R2: The 2-bit window code selects the window length in valid symbols: code 0 gives 256, code 1 gives 512, code 2 gives 1024 and code 3 gives 2048. The outputs update on the clock edge that accepts the last valid symbol of the window, and never earlier.
- R3: A symbol is counted only when the valid input and the in-area flag are both 1. Cycles with the valid input at 0 neither count nor advance the window, whatever the in-area flag is.
- R4: The window count saturates at 255. A window with 255 or more flagged symbols reports 255.
- R5: At the end of a window, the count, including the final symbol, is transferred to the held count output. The running count restarts from zero, so each window reports only its own symbols.
- R6: At the end of a window, lock becomes 1 if the count is less than or equal to the threshold, and 0 if the count is greater than the threshold.
- R7: The detector select output is 1 (phase-only detector) exactly when lock is 1, and 0 (phase-frequency detector) otherwise.
- R8: Between window ends, the held count, the lock flag and the detector select do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | A decided symbol is present this cycle |
| in_area | input | 1 | The present symbol fell inside an error-indicating region |
| win_sel | input | 2 | Window length code: 256 symbols shifted left by the code |
| lock_thresh | input | 8 | Highest count that still declares lock |
| area_count | output | 8 | Count held from the last complete window |
| lock | output | 1 | 1 when the loops are judged converged |
| det_sel | output | 1 | Carrier detector select: 1 phase-only, 0 phase-frequency |

## Verification
Windows are driven with the flagged symbols bunched at the start, spread evenly across the window, or interleaved with idle cycles that carry a raised in-area flag. These patterns show whether only valid symbols are counted, and whether the window length counts symbols rather than clock cycles. The flagged counts are chosen to sit just below, exactly at and just above the threshold, and beyond 255. This separates the less-or-equal rule from a strict comparison and shows whether the counter saturates or wraps. A saturated window is followed by a short, lightly flagged one to show that the count is cleared. Every cycle between window ends is compared with the last result, so an early update at any window code is caught.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
   // Carrier-recovery detector choice driven by the lock decision
   typedef enum logic {
      DET_PHASE_FREQ = 1'b0,
      DET_PHASE_ONLY = 1'b1
   } det_mode_e;
endpackage

// File: rtl/lkd_window_timer.sv
module lkd_window_timer #(
   parameter int MIN_WIN_LOG2 = 8,
   parameter int SEL_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic [SEL_W-1:0] win_sel,
   output logic             win_end
);
   localparam int POS_W = MIN_WIN_LOG2 + (1 << SEL_W) - 1;

   logic [POS_W-1:0] pos;
   logic [POS_W:0]   len_m1;

   always_comb begin
      len_m1  = ((POS_W+1)'(1) << (MIN_WIN_LOG2 + 32'(win_sel))) - (POS_W+1)'(1);
      win_end = sym_valid && ({1'b0, pos} >= len_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos <= '0;
      else if (win_end) pos <= '0;
      else if (sym_valid) pos <= pos + 1'b1;
   end
endmodule

// File: rtl/lkd_area_counter.sv
module lkd_area_counter #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic             in_area,
   input  logic             win_end,
   output logic [CNT_W-1:0] run_cnt,
   output logic [CNT_W-1:0] win_total
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             hit;
   logic [CNT_W-1:0] bumped;

   assign hit = sym_valid & in_area;

   generate
      if (SATURATE) begin : g_sat
         assign bumped = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
      end else begin : g_wrap
         assign bumped = run_cnt + 1'b1;
      end
   endgenerate

   assign win_total = hit ? bumped : run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_cnt <= '0;
      else if (win_end) run_cnt <= '0;
      else if (hit)     run_cnt <= bumped;
   end
endmodule

// File: rtl/lkd_lock_decider.sv
module lkd_lock_decider #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  logic [CNT_W-1:0] win_total,
   input  logic [CNT_W-1:0] thresh,
   output logic [CNT_W-1:0] held_cnt,
   output logic             lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_cnt <= '1;
         lock     <= 1'b0;
      end else if (win_end) begin
         held_cnt <= win_total;
         lock     <= (win_total <= thresh);
      end
   end
endmodule

// File: rtl/area_lock_detector.sv
module area_lock_detector
   import lkd_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int SEL_W        = 2,
   parameter int MIN_WIN_LOG2 = 8,
   parameter bit SATURATE     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic             in_area,
   input  logic [SEL_W-1:0] win_sel,
   input  logic [CNT_W-1:0] lock_thresh,
   output logic [CNT_W-1:0] area_count,
   output logic             lock,
   output logic             det_sel
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("area_lock_detector: CNT_W out of range");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("area_lock_detector: SEL_W out of range");
      end
      if (MIN_WIN_LOG2 < 1 || MIN_WIN_LOG2 > 16) begin : g_bad_win
         $error("area_lock_detector: MIN_WIN_LOG2 out of range");
      end
   endgenerate

   logic             win_end;
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] win_total;
   det_mode_e        det_mode;

   lkd_window_timer #(.MIN_WIN_LOG2(MIN_WIN_LOG2), .SEL_W(SEL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .win_sel(win_sel),
      .win_end(win_end)
   );

   lkd_area_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .in_area(in_area),
      .win_end(win_end), .run_cnt(run_cnt), .win_total(win_total)
   );

   lkd_lock_decider #(.CNT_W(CNT_W)) u_decide (
      .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_total(win_total),
      .thresh(lock_thresh), .held_cnt(area_count), .lock(lock)
   );

   assign det_mode = lock ? DET_PHASE_ONLY : DET_PHASE_FREQ;
   assign det_sel  = det_mode;
endmodule

// File: rtl/lkd_checker.sv
module lkd_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sym_valid,
   input logic             in_area,
   input logic             win_end,
   input logic [CNT_W-1:0] run_cnt,
   input logic [CNT_W-1:0] lock_thresh,
   input logic [CNT_W-1:0] area_count,
   input logic             lock,
   input logic             det_sel
);
   // R1: reset forces the idle result
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (lock == 1'b0 && det_sel == 1'b0 && area_count == '1));

   // R4: a full counter stays full within the window
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == '1 && sym_valid && in_area && !win_end) |=> run_cnt == '1);

   // R5: the running count restarts after a window end
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> run_cnt == '0);

   // R6: lock follows the held count against the threshold of that edge
   p_lock_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (lock == (area_count <= $past(lock_thresh))));

   // R8: results hold between window ends
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> ($stable(area_count) && $stable(lock) && $stable(det_sel)));

   // R7: the detector select agrees with lock after every update
   p_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(lock) |-> (det_sel == lock));
endmodule

bind area_lock_detector lkd_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .in_area(in_area),
   .win_end(win_end), .run_cnt(run_cnt), .lock_thresh(lock_thresh),
   .area_count(area_count), .lock(lock), .det_sel(det_sel)
);

// File: tb/area_lock_detector_tb.sv
`timescale 1ns/1ps
module area_lock_detector_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_valid = 1'b0;
   logic       in_area = 1'b0;
   logic [1:0] win_sel = 2'd0;
   logic [7:0] lock_thresh = 8'd0;
   logic [7:0] area_count;
   logic       lock;
   logic       det_sel;

   always #2.5 clk = ~clk;

   area_lock_detector u_dut (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .in_area(in_area),
      .win_sel(win_sel), .lock_thresh(lock_thresh), .area_count(area_count),
      .lock(lock), .det_sel(det_sel)
   );

   typedef struct packed { logic [7:0] cnt; logic lk; } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   int    req_cnt = 0;
   int    ack_cnt = 0;
   bit    monitor_on = 1'b0;
   bit    done = 1'b0;

   task automatic compare(string tag, exp_t e);
      checks++;
      if (area_count !== e.cnt || lock !== e.lk || det_sel !== e.lk) begin
         errors++;
         $display("FAIL %s: count=%0d lock=%0b sel=%0b expected count=%0d lock=%0b sel=%0b",
                  tag, area_count, lock, det_sel, e.cnt, e.lk, e.lk);
      end
   endtask

   // Monitor: pops a result when one is due, otherwise checks the hold (R8)
   initial begin : monitor
      exp_t held;
      held = '{cnt: 8'hFF, lk: 1'b0};
      forever begin
         @(negedge clk);
         if (monitor_on) begin
            if (ack_cnt != req_cnt) begin
               exp_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               compare(t, e);
               held = e;
               ack_cnt++;
            end else begin
               compare("R8 hold between windows", held);
            end
         end
      end
   end

   // Driver: one window of symbols; pushes the expected result
   task automatic run_window(input logic [1:0] code, input logic [7:0] thr,
                             input int n_area, input bit spread, input bit gaps,
                             input string tag);
      int   n_sym;
      int   flagged;
      int   stride;
      exp_t e;
      n_sym   = 256 << code;
      flagged = 0;
      stride  = (n_area > 0 && spread) ? n_sym / n_area : 1;
      @(negedge clk);
      win_sel     = code;
      lock_thresh = thr;
      for (int i = 0; i < n_sym; i++) begin
         bit f;
         if (gaps && (i % 7 == 3)) begin
            sym_valid = 1'b0;   // R3: idle cycle with flag raised
            in_area   = 1'b1;
            @(negedge clk);
         end
         f = spread ? (n_area > 0 && (i % stride) == 0 && flagged < n_area)
                    : (i < n_area);
         if (f) flagged++;
         sym_valid = 1'b1;
         in_area   = f;
         if (i == n_sym - 1) begin
            e.cnt = (flagged > 255) ? 8'd255 : 8'(flagged);
            e.lk  = (e.cnt <= thr);
            exp_q.push_back(e);
            tag_q.push_back(tag);
            @(posedge clk);
            #1 req_cnt++;
         end
         @(negedge clk);
      end
      sym_valid = 1'b0;
      in_area   = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: values during reset
      compare("R1 during reset", '{cnt: 8'hFF, lk: 1'b0});
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release", '{cnt: 8'hFF, lk: 1'b0});
      monitor_on = 1'b1;

      run_window(2'd0, 8'd10, 5,   1'b0, 1'b0, "R2 R6 R7 code0 below threshold");
      run_window(2'd0, 8'd10, 10,  1'b1, 1'b0, "R6 equal to threshold locks");
      run_window(2'd0, 8'd10, 11,  1'b1, 1'b0, "R6 R7 one above threshold unlocks");
      run_window(2'd1, 8'd100, 300, 1'b0, 1'b0, "R4 R2 code1 saturation");
      run_window(2'd0, 8'd20, 3,   1'b1, 1'b1, "R5 R3 cleared after saturation, idle flags ignored");
      run_window(2'd2, 8'd0,  0,   1'b0, 1'b1, "R2 R6 code2 zero count zero threshold");
      run_window(2'd3, 8'd254, 255, 1'b1, 1'b0, "R2 R4 code3 count 255 above 254");
      run_window(2'd0, 8'd255, 256, 1'b0, 1'b0, "R4 R6 saturated at threshold 255");
      run_window(2'd1, 8'd7,  7,   1'b1, 1'b1, "R6 R7 relock code1 with gaps");

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule